// File: doc/BRIEF.md
# Sampling Trigger and Transfer Controller

This block sequences a 12-bit analog-to-digital converter behind a byte-wide register bus with sixteen locations. It picks where each conversion request comes from (a write by software, an internal pacer, or an edge on an external trigger pin) and runs a start/done handshake with the converter. It stores the result so software can read it as two bytes, and reports completion in one of three ways: polled status, a sticky interrupt flag, or a DMA request that pushes the two result bytes onto the data bus.

The pacer is two 16-bit dividers in cascade. The first counts strobes of the fixed 2 MHz time base (`tick_2m`, a one-cycle enable in the system clock domain). The second counts output pulses of the first. Each output pulse of the second stage is one sample request, so the sample period is the product of the two divider values in time-base ticks. A divider value of zero stops the pacer. A conversion takes about 8 µs, so software keeps the product above 20, which holds the rate at or below 100 kHz. The channel register drives the input selection toward the external multiplexer. Two bank-enable bits choose the lower or the upper eight inputs, and setting both bits flags differential operation.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00 (software trigger, polled transfer), the status byte at offset 13 reads 0x01 (ready bit high, not busy, no overrun), the channel register reads 0x10, both result bytes read 0x00, and `irq`, `dma_req` and `conv_start` are low.
- R2: With trigger source 0 selected, a write of any value to offset 12 starts exactly one conversion, seen as a `conv_start` pulse lasting one cycle.
- R3: The result read at offset 4 is bits 7..0 of the converted value. The result read at offset 5 is bits 11..8 in bits 3..0, with bits 7..4 always zero.
- R4: The ready bit (status offset 13, bit 0) is active low. It falls on the cycle after `conv_done` ends a conversion, and it returns high after a read of offset 5.
- R5: A request from the selected trigger source that arrives while a conversion is busy starts nothing. It sets the overrun bit (status bit 2), which stays set until the status byte is read.
- R6: In transfer mode 1 (interrupt), each completion sets `irq`. The flag holds until any value is written to offset 8. If a completion falls in the same cycle as that write, the flag stays set. In polled mode no completion raises `irq` or `dma_req`.
- R7: In transfer mode 2 (DMA), each completion raises `dma_req`, which holds until `dma_ack` is seen. The first acknowledged cycle drives the low result byte onto `bus_rdata` and the second drives the high byte. After that, `dma_req` drops and the ready bit returns high.
- R8: With trigger source 1 (pacer), conversions start every A×B time-base ticks. A is the 16-bit value at offsets 0 (low byte) and 1 (high byte), and B is the value at offsets 2 and 3.
- R9: A zero in either pacer divider stops pacer requests. Loading nonzero values in both resumes them.
- R10: With trigger source 2 (external), each rising edge of `ext_trig` starts one conversion after a two-flop synchroniser. Requests from sources that are not selected are ignored, and trigger source 3 selects none.
- R11: The channel register at offset 9 holds the channel in bits 3..0, the lower-bank enable in bit 4 and the upper-bank enable in bit 5. These drive `mux_chan` and `bank_en`, and `diff_mode` is high when both enables are set.
- R12: The mode register at offset 11 holds the trigger source in bits 1..0 and the transfer mode in bits 3..2. It reads back with bits 7..4 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational), or DMA byte while acknowledged |
| tick_2m | input | 1 | Pacer time-base strobe |
| ext_trig | input | 1 | External trigger, asynchronous |
| conv_start | output | 1 | Start pulse to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter result, valid with `conv_done` |
| mux_chan | output | 4 | Selected input channel |
| bank_en | output | 2 | Bank enables: bit 0 lower eight, bit 1 upper eight |
| diff_mode | output | 1 | Both banks enabled |
| irq | output | 1 | Interrupt flag |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |

## Verification
Two functions can fall in the same cycle: a converter completion can arrive on the very cycle that software writes the interrupt-clear address. The bench drives `conv_done` by hand and puts the clear write in the same cycle. It then expects `irq` to stay high, because the new completion wins. The other checks sweep pacer divider pairs, measuring start-to-start spacing against A×B×tick spacing, sweep all channel and bank combinations, and test each trigger source against the unselected ones.

// File: rtl/adc_seq_pkg.sv
// Shared types and register offsets for the sampling controller.
// Assumes a byte-wide bus with a 4-bit offset.
package adc_seq_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        TRIG_SOFT  = 2'd0,
        TRIG_PACER = 2'd1,
        TRIG_EXT   = 2'd2,
        TRIG_NONE  = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        XFER_POLL = 2'd0,
        XFER_IRQ  = 2'd1,
        XFER_DMA  = 2'd2,
        XFER_RSVD = 2'd3
    } xfer_e;

    typedef struct packed {
        xfer_e     xfer;
        trig_src_e trig;
    } mode_t;

    localparam logic [ADDR_W-1:0] OFS_DIVA_LO = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_DIVA_HI = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_DIVB_LO = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_DIVB_HI = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_RES_LO  = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_RES_HI  = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_IRQ_CLR = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_CHAN    = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_MODE    = 4'd11;
    localparam logic [ADDR_W-1:0] OFS_SWTRIG  = 4'd12;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'd13;
endpackage

// File: rtl/adc_div_stage.sv
// One pacer divider stage: emits a pulse once every DIV enabled cycles.
// Assumes: load comes one cycle after the divider value changes; div==0 halts.
module adc_div_stage #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [DIV_W-1:0] div,
    output logic             pulse
);
    logic [DIV_W-1:0] cnt_q;
    logic             active;

    assign active = en && (div != '0) && !load;
    assign pulse  = active && (cnt_q <= DIV_W'(1));

    // Count down enabled cycles, reloading on terminal count or on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= div;
        else if (active)
            cnt_q <= (cnt_q <= DIV_W'(1)) ? div : cnt_q - DIV_W'(1);
    end
endmodule

// File: rtl/adc_pacer.sv
// Cascaded divider pacer: stage 0 counts time-base ticks, each later stage
// counts pulses of the stage before it; the last stage's pulse is a request.
// Assumes a zero in any stage halts everything downstream of it.
module adc_pacer #(
    parameter int DIV_W  = 16,
    parameter int STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic [STAGES-1:0][DIV_W-1:0] div,
    input  logic [STAGES-1:0]            load,
    output logic                         req
);
    logic [STAGES:0] chain;

    assign chain[0] = tick;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            adc_div_stage #(.DIV_W(DIV_W)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (chain[s]),
                .load  (load[s]),
                .div   (div[s]),
                .pulse (chain[s+1])
            );
        end
    endgenerate

    assign req = chain[STAGES];
endmodule

// File: rtl/adc_bus_regs.sv
// Register file and bus decode: divider, mode and channel registers, command
// strobes and the combinational read mux (DMA bytes override normal reads).
// Assumes one-cycle read/write strobes; a read during an acknowledged DMA cycle
// has no side effect.
module adc_bus_regs
    import adc_seq_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int RES_W  = 12,
    parameter int CHAN_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [DIV_W-1:0]      div_a,
    output logic [DIV_W-1:0]      div_b,
    output logic                  div_a_ld,
    output logic                  div_b_ld,
    output mode_t                 mode,
    output logic [CHAN_W+1:0]     chan_cfg,
    output logic                  sw_trig,
    output logic                  irq_clr,
    output logic                  status_rd,
    output logic                  reshi_rd,
    input  logic [RES_W-1:0]      result,
    input  logic                  ready_n,
    input  logic                  busy,
    input  logic                  overrun,
    input  logic                  dma_req,
    input  logic                  dma_ack,
    input  logic                  dma_phase
);
    localparam int DIV_HI_W = DIV_W - DATA_W;
    localparam int RES_HI_W = RES_W - DATA_W;
    localparam logic [CHAN_W+1:0] CHAN_RST = (CHAN_W+2)'(1) << CHAN_W;

    logic dma_xfer;
    logic rd_eff;
    logic wr_a, wr_b;

    assign dma_xfer  = dma_req && dma_ack;
    assign rd_eff    = bus_rd && !dma_xfer;
    assign sw_trig   = bus_wr && (bus_addr == OFS_SWTRIG);
    assign irq_clr   = bus_wr && (bus_addr == OFS_IRQ_CLR);
    assign status_rd = rd_eff && (bus_addr == OFS_STATUS);
    assign reshi_rd  = rd_eff && (bus_addr == OFS_RES_HI);
    assign wr_a      = bus_wr && ((bus_addr == OFS_DIVA_LO) || (bus_addr == OFS_DIVA_HI));
    assign wr_b      = bus_wr && ((bus_addr == OFS_DIVB_LO) || (bus_addr == OFS_DIVB_HI));

    // Hold the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_a    <= '0;
            div_b    <= '0;
            mode     <= '0;
            chan_cfg <= CHAN_RST;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DIVA_LO: div_a[DATA_W-1:0]     <= bus_wdata;
                OFS_DIVA_HI: div_a[DIV_W-1:DATA_W] <= bus_wdata[DIV_HI_W-1:0];
                OFS_DIVB_LO: div_b[DATA_W-1:0]     <= bus_wdata;
                OFS_DIVB_HI: div_b[DIV_W-1:DATA_W] <= bus_wdata[DIV_HI_W-1:0];
                OFS_MODE:    mode                  <= mode_t'(bus_wdata[3:0]);
                OFS_CHAN:    chan_cfg              <= bus_wdata[CHAN_W+1:0];
                default: ;
            endcase
        end
    end

    // Delay divider-load strobes so stages reload with the updated value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_a_ld <= 1'b0;
            div_b_ld <= 1'b0;
        end else begin
            div_a_ld <= wr_a;
            div_b_ld <= wr_b;
        end
    end

    // Select read data: DMA byte while acknowledged, else addressed register.
    always_comb begin
        bus_rdata = '0;
        if (dma_xfer) begin
            bus_rdata = dma_phase ? DATA_W'(result[RES_W-1:DATA_W]) : result[DATA_W-1:0];
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_DIVA_LO: bus_rdata = div_a[DATA_W-1:0];
                OFS_DIVA_HI: bus_rdata = DATA_W'(div_a[DIV_W-1:DATA_W]);
                OFS_DIVB_LO: bus_rdata = div_b[DATA_W-1:0];
                OFS_DIVB_HI: bus_rdata = DATA_W'(div_b[DIV_W-1:DATA_W]);
                OFS_RES_LO:  bus_rdata = result[DATA_W-1:0];
                OFS_RES_HI:  bus_rdata = DATA_W'(result[RES_W-1:RES_W-RES_HI_W]);
                OFS_CHAN:    bus_rdata = DATA_W'(chan_cfg);
                OFS_MODE:    bus_rdata = DATA_W'(mode);
                OFS_STATUS:  bus_rdata = DATA_W'({overrun, busy, ready_n});
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: accepts one request when idle, handshakes with the
// converter, latches the result and updates ready, overrun, interrupt and DMA.
// Assumes conv_done is a single-cycle pulse; a done while idle is ignored.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  xfer_e            xfer,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             irq_clr,
    input  logic             status_rd,
    input  logic             reshi_rd,
    input  logic             dma_ack,
    output logic             conv_start,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             ready_n,
    output logic             overrun,
    output logic             irq,
    output logic             dma_req,
    output logic             dma_phase
);
    logic accept;
    logic done_ok;
    logic dma_last;

    assign accept   = trig && !busy;
    assign done_ok  = conv_done && busy;
    assign dma_last = dma_req && dma_ack && dma_phase;

    // Track the busy window and issue the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= accept;
            if (accept)
                busy <= 1'b1;
            else if (done_ok)
                busy <= 1'b0;
        end
    end

    // Latch the result and drive the active-low ready bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            ready_n <= 1'b1;
        end else if (done_ok) begin
            result  <= conv_data;
            ready_n <= 1'b0;
        end else if (reshi_rd || dma_last) begin
            ready_n <= 1'b1;
        end
    end

    // Record requests lost to a busy converter; a status read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (trig && busy)
            overrun <= 1'b1;
        else if (status_rd)
            overrun <= 1'b0;
    end

    // Sticky interrupt flag; a completion beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (done_ok && (xfer == XFER_IRQ))
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end

    // DMA request and two-beat byte sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req   <= 1'b0;
            dma_phase <= 1'b0;
        end else if (done_ok && (xfer == XFER_DMA)) begin
            dma_req   <= 1'b1;
            dma_phase <= 1'b0;
        end else if (dma_req && dma_ack) begin
            if (dma_phase) begin
                dma_req   <= 1'b0;
                dma_phase <= 1'b0;
            end else begin
                dma_phase <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the sampling controller: selects the trigger source, synchronises
// the external trigger and joins the register file, pacer and sequencer.
// Assumes tick_2m is a one-cycle strobe at the pacer time-base rate.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int RES_W       = 12,
    parameter int CHAN_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tick_2m,
    input  logic              ext_trig,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic [CHAN_W-1:0] mux_chan,
    output logic [1:0]        bank_en,
    output logic              diff_mode,
    output logic              irq,
    output logic              dma_req,
    input  logic              dma_ack
);
    localparam int PACER_STAGES = 2;

    logic [DIV_W-1:0]        div_a, div_b;
    logic                    div_a_ld, div_b_ld;
    mode_t                   mode;
    logic [CHAN_W+1:0]       chan_cfg;
    logic                    sw_trig, irq_clr, status_rd, reshi_rd;
    logic [RES_W-1:0]        result;
    logic                    ready_n, busy, overrun, dma_phase;
    logic                    pacer_req, ext_rise, trig;
    logic [SYNC_STAGES:0]    ext_q;

    adc_bus_regs #(.DIV_W(DIV_W), .RES_W(RES_W), .CHAN_W(CHAN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .div_a     (div_a),
        .div_b     (div_b),
        .div_a_ld  (div_a_ld),
        .div_b_ld  (div_b_ld),
        .mode      (mode),
        .chan_cfg  (chan_cfg),
        .sw_trig   (sw_trig),
        .irq_clr   (irq_clr),
        .status_rd (status_rd),
        .reshi_rd  (reshi_rd),
        .result    (result),
        .ready_n   (ready_n),
        .busy      (busy),
        .overrun   (overrun),
        .dma_req   (dma_req),
        .dma_ack   (dma_ack),
        .dma_phase (dma_phase)
    );

    adc_pacer #(.DIV_W(DIV_W), .STAGES(PACER_STAGES)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_2m),
        .div   ({div_b, div_a}),
        .load  ({div_b_ld, div_a_ld}),
        .req   (pacer_req)
    );

    // Synchronise the external trigger and keep one extra stage for edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_q <= '0;
        else
            ext_q <= {ext_q[SYNC_STAGES-1:0], ext_trig};
    end

    assign ext_rise = ext_q[SYNC_STAGES-1] && !ext_q[SYNC_STAGES];

    // Pass only the request of the selected trigger source.
    always_comb begin
        case (mode.trig)
            TRIG_SOFT:  trig = sw_trig;
            TRIG_PACER: trig = pacer_req;
            TRIG_EXT:   trig = ext_rise;
            default:    trig = 1'b0;
        endcase
    end

    adc_conv_seq #(.RES_W(RES_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .xfer       (mode.xfer),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .irq_clr    (irq_clr),
        .status_rd  (status_rd),
        .reshi_rd   (reshi_rd),
        .dma_ack    (dma_ack),
        .conv_start (conv_start),
        .busy       (busy),
        .result     (result),
        .ready_n    (ready_n),
        .overrun    (overrun),
        .irq        (irq),
        .dma_req    (dma_req),
        .dma_phase  (dma_phase)
    );

    assign mux_chan  = chan_cfg[CHAN_W-1:0];
    assign bank_en   = chan_cfg[CHAN_W+1:CHAN_W];
    assign diff_mode = &bank_en;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Protocol checker for the sampling controller, bound into the top module.
// Assumes the top exposes its busy and ready_n nets.
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       conv_start,
    input logic       conv_done,
    input logic       irq,
    input logic       dma_req,
    input logic       dma_ack,
    input logic       busy,
    input logic       ready_n
);
    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> !conv_start);

    // R4
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> $past(conv_done && busy));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && bus_addr == OFS_IRQ_CLR)) |=> irq);

    // R7
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    // R3
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !dma_req && bus_addr == OFS_RES_HI) |-> (bus_rdata[7:4] == 4'h0));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .irq        (irq),
    .dma_req    (dma_req),
    .dma_ack    (dma_ack),
    .busy       (busy),
    .ready_n    (ready_n)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int CONV_LAT = 6;
    localparam int TICK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tick_2m = 1'b0, ext_trig = 1'b0;
    logic        conv_start, conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [3:0]  mux_chan;
    logic [1:0]  bank_en;
    logic        diff_mode, irq, dma_req;
    logic        dma_ack = 1'b0;

    int tests = 0, fails = 0, starts = 0, conv_idx = 0;
    bit model_auto = 1'b1, finished = 1'b0;

    always #4 clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_2m(tick_2m), .ext_trig(ext_trig),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .mux_chan(mux_chan), .bank_en(bank_en), .diff_mode(diff_mode), .irq(irq),
        .dma_req(dma_req), .dma_ack(dma_ack)
    );

    function automatic logic [11:0] pat(input int i);
        return 12'((i * 1237 + 291) % 4096);
    endfunction

    // time base: one strobe every TICK_DIV cycles
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % TICK_DIV;
            tick_2m = (tc == 0);
        end
    end

    // count start pulses (value of the previous cycle)
    always @(posedge clk) if (conv_start) starts <= starts + 1;

    // converter model
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start && model_auto) begin
                repeat (CONV_LAT) @(negedge clk);
                conv_data = pat(conv_idx);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                conv_idx++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_ready(output logic [7:0] d);
        for (int k = 0; k < 100; k++) begin
            bus_read(4'd13, d);
            if (!d[0]) break;
        end
    endtask

    task automatic set_div(input int a, input int b);
        bus_write(4'd0, 8'(a)); bus_write(4'd1, 8'(a >> 8));
        bus_write(4'd2, 8'(b)); bus_write(4'd3, 8'(b >> 8));
    endtask

    task automatic next_start_gap(output int gap);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!conv_start && gap < 20000);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=expired expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d, d0, d1;
        logic [11:0] e;
        int s0, g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(irq == 0 && dma_req == 0 && conv_start == 0, "R1 outputs", {irq, dma_req, conv_start}, 0);
        bus_read(4'd11, d); chk(d == 8'h00, "R1 mode", d, 0);
        bus_read(4'd13, d); chk(d == 8'h01, "R1 status", d, 1);
        bus_read(4'd9, d);  chk(d == 8'h10, "R1 chan", d, 16);
        bus_read(4'd4, d);  chk(d == 8'h00, "R1 res lo", d, 0);
        bus_read(4'd5, d);  chk(d == 8'h00, "R1 res hi", d, 0);
        chk(mux_chan == 0 && bank_en == 2'b01 && !diff_mode, "R1 mux", {mux_chan, bank_en}, 1);

        // R12 mode readback
        bus_write(4'd11, 8'h09); bus_read(4'd11, d); chk(d == 8'h09, "R12 mode", d, 9);
        bus_write(4'd11, 8'hF6); bus_read(4'd11, d); chk(d == 8'h06, "R12 upper bits", d, 6);
        bus_write(4'd11, 8'h00);

        // R2 R3 R4 polled software conversions
        for (int i = 0; i < 6; i++) begin
            e = pat(conv_idx);
            s0 = starts;
            bus_write(4'd12, 8'(i));
            wait_ready(d);
            chk(d[0] == 1'b0, "R4 ready low", d[0], 0);
            chk(starts == s0 + 1, "R2 one start", starts - s0, 1);
            bus_read(4'd4, d); chk(d == e[7:0], "R3 low byte", d, e[7:0]);
            bus_read(4'd5, d); chk(d == {4'h0, e[11:8]}, "R3 high byte", d, {4'h0, e[11:8]});
            bus_read(4'd13, d); chk(d[0] == 1'b1, "R4 ready rearm", d[0], 1);
            chk(irq == 0 && dma_req == 0, "R6 poll no flag", {irq, dma_req}, 0);
        end

        // R5 overrun
        s0 = starts;
        bus_write(4'd12, 8'h00);
        bus_write(4'd12, 8'h00);
        repeat (20) @(negedge clk);
        bus_read(4'd13, d); chk(d[2] == 1'b1, "R5 overrun set", d[2], 1);
        chk(starts == s0 + 1, "R5 ignored trigger", starts - s0, 1);
        bus_read(4'd13, d); chk(d[2] == 1'b0, "R5 overrun cleared", d[2], 0);
        bus_read(4'd5, d);

        // R6 interrupt mode with a hand-driven converter
        model_auto = 1'b0;
        bus_write(4'd11, 8'h04);
        bus_write(4'd12, 8'h00);
        repeat (2) @(negedge clk);
        @(negedge clk); conv_data = 12'hA5C; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        chk(irq == 1'b1, "R6 irq set", irq, 1);
        repeat (10) @(negedge clk);
        chk(irq == 1'b1, "R6 irq held", irq, 1);
        bus_write(4'd8, 8'h5A);
        chk(irq == 1'b0, "R6 irq cleared", irq, 0);
        bus_write(4'd12, 8'h00);
        repeat (2) @(negedge clk);
        @(negedge clk); conv_data = 12'h3C7; conv_done = 1'b1; bus_addr = 4'd8; bus_wr = 1'b1;
        @(negedge clk); conv_done = 1'b0; bus_wr = 1'b0;
        chk(irq == 1'b1, "R6 completion beats clear", irq, 1);
        bus_read(4'd4, d); chk(d == 8'hC7, "R3 irq result", d, 8'hC7);
        bus_write(4'd8, 8'h00);
        chk(irq == 1'b0, "R6 irq cleared again", irq, 0);
        bus_read(4'd5, d);
        model_auto = 1'b1;

        // R7 DMA mode
        bus_write(4'd11, 8'h08);
        e = pat(conv_idx);
        bus_write(4'd12, 8'h00);
        for (int k = 0; k < 50 && !dma_req; k++) @(negedge clk);
        chk(dma_req == 1'b1, "R7 request", dma_req, 1);
        repeat (5) @(negedge clk);
        chk(dma_req == 1'b1, "R7 request held", dma_req, 1);
        @(negedge clk); dma_ack = 1'b1; #1 d0 = bus_rdata;
        @(negedge clk); #1 d1 = bus_rdata;
        @(negedge clk); dma_ack = 1'b0;
        chk(d0 == e[7:0], "R7 first byte", d0, e[7:0]);
        chk(d1 == {4'h0, e[11:8]}, "R7 second byte", d1, {4'h0, e[11:8]});
        chk(dma_req == 1'b0, "R7 request dropped", dma_req, 0);
        bus_read(4'd13, d); chk(d[0] == 1'b1, "R7 ready rearm", d[0], 1);

        // R8 pacer spacing sweep
        bus_write(4'd11, 8'h01);
        for (int p = 0; p < 7; p++) begin
            int da, db;
            case (p)
                0: begin da = 3;   db = 7;  end
                1: begin da = 7;   db = 3;  end
                2: begin da = 5;   db = 5;  end
                3: begin da = 1;   db = 21; end
                4: begin da = 21;  db = 1;  end
                5: begin da = 258; db = 1;  end
                default: begin da = 2; db = 11; end
            endcase
            set_div(da, db);
            next_start_gap(g);
            next_start_gap(g);
            next_start_gap(g);
            chk(g == da * db * TICK_DIV, "R8 period", g, da * db * TICK_DIV);
            next_start_gap(g);
            chk(g == da * db * TICK_DIV, "R8 period repeat", g, da * db * TICK_DIV);
        end

        // R9 zero halts
        set_div(0, 7);
        repeat (20) @(negedge clk);
        s0 = starts;
        repeat (600) @(negedge clk);
        chk(starts == s0, "R9 first divider zero", starts - s0, 0);
        set_div(3, 0);
        repeat (20) @(negedge clk);
        s0 = starts;
        repeat (600) @(negedge clk);
        chk(starts == s0, "R9 second divider zero", starts - s0, 0);
        set_div(3, 7);
        repeat (200) @(negedge clk);
        chk(starts > s0, "R9 resumes", starts - s0, 1);

        // R10 external trigger and source gating
        bus_write(4'd11, 8'h02);
        repeat (20) @(negedge clk);
        s0 = starts;
        repeat (300) @(negedge clk);
        chk(starts == s0, "R10 pacer ignored", starts - s0, 0);
        bus_write(4'd12, 8'h00);
        repeat (20) @(negedge clk);
        chk(starts == s0, "R10 software ignored", starts - s0, 0);
        for (int k = 1; k <= 2; k++) begin
            @(negedge clk); ext_trig = 1'b1;
            repeat (12) @(negedge clk); ext_trig = 1'b0;
            repeat (20) @(negedge clk);
            chk(starts == s0 + k, "R10 edge start", starts - s0, k);
        end
        bus_write(4'd11, 8'h00);
        repeat (10) @(negedge clk);
        s0 = starts;
        @(negedge clk); ext_trig = 1'b1;
        repeat (12) @(negedge clk); ext_trig = 1'b0;
        repeat (20) @(negedge clk);
        chk(starts == s0, "R10 ext ignored in software mode", starts - s0, 0);
        bus_write(4'd11, 8'h03);
        bus_write(4'd12, 8'h00);
        repeat (20) @(negedge clk);
        chk(starts == s0, "R10 source 3 none", starts - s0, 0);

        // R11 channel sweep
        for (int b = 1; b < 4; b++) begin
            for (int c = 0; c < 16; c++) begin
                bus_write(4'd9, 8'((b << 4) | c));
                bus_read(4'd9, d);
                chk(d == 8'((b << 4) | c) && mux_chan == 4'(c) && bank_en == 2'(b)
                    && diff_mode == (b == 3), "R11 channel", d, (b << 4) | c);
            end
        end

        finish_run();
    end
endmodule